// File: doc/BRIEF.md
# Display Memory Read Master

This block lets a display controller take over a shared 16-bit multiplexed address/data bus and read runs of words from display memory. A display-side client asks for a run by pulsing a request with a start word address and a word count. The block then pulls an active-low bus request line to claim the bus. It waits a programmable warning time so that the host processor can finish whatever cycle it has in flight. After the wait it performs one word read per three clock cycles, back to back. In each read it drives the word address onto the bus, latches that address externally with an address strobe, floats the bus, and asserts the upper and lower data strobes together. It then captures the 16-bit word. Finally it floats its drivers, spends one drain cycle, and lets go of the bus request.

Word addresses name the even (upper) byte of each pair, so the 16-bit word address covers 128 Kbytes. The block never writes; its read/write line always signals read. The warning time is a 5-bit value in units of six clock cycles, and anything above 23 units is clamped to 23.

The controller has six states. IDLE goes to WARN when a run is accepted with a nonzero warning, or straight to ADDR when the warning is zero. WARN goes to ADDR when the timer runs out. ADDR goes to STRB, and STRB goes to SAMP. SAMP goes back to ADDR while words remain, or to DRAIN after the last word. DRAIN goes back to IDLE.

Top module: `dispbus_master`

## Requirements
- R1: After reset, bus_req_n, as_n, uds_n and lds_n are 1, ad_oe is 0, word_valid is 0 and busy is 0.
- R2: A request is accepted only in IDLE and only with a nonzero fetch_count. A request with count 0, or a request made while a run is in progress, is ignored: no extra words are read and bus_req_n stays high once the run ends.
- R3: bus_req_n falls in the cycle after acceptance. ad_oe first rises exactly 6*W cycles after that fall, where W is warn_units (0 gives no gap).
- R4: Each word read takes three cycles. In ADDR, ad_oe is 1, ad_out holds the word address and as_n, uds_n and lds_n are high. In STRB and SAMP, ad_oe is 0, as_n is 0, and uds_n and lds_n are both 0.
- R5: rw is 1 at all times.
- R6: The value on ad_in at the end of SAMP appears on word_data, with word_valid high for exactly that one following cycle.
- R7: The words of a run are read at start, start+1, and so on, wrapping modulo 2^16, and exactly fetch_count words are read.
- R8: After the last word there is one DRAIN cycle in which ad_oe is 0, the strobes are high and bus_req_n is still 0. In the next cycle bus_req_n is 1.
- R9: busy is 1 from the cycle after acceptance until the return to IDLE, and bus_req_n is never low while busy is 0.
- R10: A warn_units value above 23 gives the same gap as 23, which is 138 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Run request, sampled in IDLE |
| fetch_addr | input | 16 | Start word address |
| fetch_count | input | 8 | Number of words in the run |
| warn_units | input | 5 | Warning time in units of 6 cycles |
| busy | output | 1 | A run is in progress |
| bus_req_n | output | 1 | Bus request, active low (open-drain pull) |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| rw | output | 1 | Read/write, always 1 (read) |
| ad_out | output | 16 | Address driven onto the multiplexed bus |
| ad_oe | output | 1 | Bus driver enable |
| ad_in | input | 16 | Data read from the multiplexed bus |
| word_data | output | 16 | Captured word |
| word_valid | output | 1 | word_data valid for one cycle |

## Verification
The hardest case to reach is a second request that arrives while a run is in the middle of its strobe phase. The ports give no sign that such a request was dropped unless the bench counts the words exactly and then watches the bus request stay released. The bench raises such a request during the first STRB of one run and then checks that the word count, the address sequence and the idle bus all stay as they were. The clamped warning value is reached by a table entry with warn_units at 31, and the 16-bit address wrap by a run that starts at 0xFFFE.

// File: rtl/dispbus_pkg.sv
package dispbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WARN  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_STRB  = 3'd3,
        ST_SAMP  = 3'd4,
        ST_DRAIN = 3'd5
    } bus_state_t;

endpackage

// File: rtl/warn_timer.sv
module warn_timer #(
    parameter int WARN_W    = 5,
    parameter int WARN_UNIT = 6,
    parameter int WARN_MAX  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [WARN_W-1:0] units,
    output logic              zero_delay,
    output logic              last
);
    localparam int TOTAL = WARN_MAX * WARN_UNIT;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [WARN_W-1:0] eff_units;
    logic [CNT_W-1:0]  load_val;
    logic [CNT_W-1:0]  cnt_q;

    // Clamp the programmed warning to the longest permitted value
    always_comb begin
        if (units > WARN_W'(WARN_MAX)) eff_units = WARN_W'(WARN_MAX);
        else                           eff_units = units;
        load_val = CNT_W'(eff_units) * CNT_W'(WARN_UNIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (load)               cnt_q <= load_val;
        else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_delay = (load_val == '0);
    assign last       = (cnt_q == CNT_W'(1));

    // R3
    run_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q != '0);

endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_word
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain_q <= '0;
        end else if (load) begin
            cur_addr <= start_addr;
            remain_q <= start_cnt;
        end else if (advance) begin
            cur_addr <= cur_addr + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last_word = (remain_q == CNT_W'(1));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> remain_q != '0);

endmodule

// File: rtl/dispbus_master.sv
module dispbus_master
    import dispbus_pkg::*;
#(
    parameter int BUS_W     = 16,
    parameter int CNT_W     = 8,
    parameter int WARN_W    = 5,
    parameter int WARN_UNIT = 6,
    parameter int WARN_MAX  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic [BUS_W-1:0]  fetch_addr,
    input  logic [CNT_W-1:0]  fetch_count,
    input  logic [WARN_W-1:0] warn_units,
    output logic              busy,
    output logic              bus_req_n,
    output logic              as_n,
    output logic              uds_n,
    output logic              lds_n,
    output logic              rw,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  word_data,
    output logic              word_valid
);
    bus_state_t state_q, state_d;

    logic             accept;
    logic             warn_zero;
    logic             warn_last;
    logic             last_word;
    logic [BUS_W-1:0] cur_addr;

    assign accept = (state_q == ST_IDLE) && fetch_req && (fetch_count != '0);

    warn_timer #(
        .WARN_W    (WARN_W),
        .WARN_UNIT (WARN_UNIT),
        .WARN_MAX  (WARN_MAX)
    ) u_warn (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .run        (state_q == ST_WARN),
        .units      (warn_units),
        .zero_delay (warn_zero),
        .last       (warn_last)
    );

    xfer_tracker #(
        .ADDR_W (BUS_W),
        .CNT_W  (CNT_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .start_addr (fetch_addr),
        .start_cnt  (fetch_count),
        .advance    (state_q == ST_SAMP),
        .cur_addr   (cur_addr),
        .last_word  (last_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = warn_zero ? ST_ADDR : ST_WARN;
            ST_WARN:  if (warn_last) state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_STRB;
            ST_STRB:  state_d = ST_SAMP;
            ST_SAMP:  state_d = last_word ? ST_DRAIN : ST_ADDR;
            ST_DRAIN: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Bus outputs decoded from the state
    always_comb begin
        bus_req_n = 1'b0;
        as_n      = 1'b1;
        uds_n     = 1'b1;
        lds_n     = 1'b1;
        ad_oe     = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                bus_req_n = 1'b1;
                busy      = 1'b0;
            end
            ST_WARN: ;
            ST_ADDR: ad_oe = 1'b1;
            ST_STRB, ST_SAMP: begin
                as_n  = 1'b0;
                uds_n = 1'b0;
                lds_n = 1'b0;
            end
            ST_DRAIN: ;
            default: begin
                bus_req_n = 1'b1;
                busy      = 1'b0;
            end
        endcase
    end

    assign ad_out = ad_oe ? cur_addr : '0;
    assign rw     = 1'b1;

    // Word capture at the close of the strobe phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= (state_q == ST_SAMP);
            if (state_q == ST_SAMP) word_data <= ad_in;
        end
    end

    // R4
    strobe_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uds_n) |-> $past(ad_oe));

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (uds_n && lds_n && as_n));

    // R8
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_n) |-> $past(!ad_oe && uds_n && as_n));

    // R6
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(!uds_n));

    // R9
    req_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n |-> busy);

endmodule

// File: tb/tb_dispbus_master.sv
module tb_dispbus_master;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    localparam logic [15:0] V_ADDR [NV] = '{16'h0100, 16'h0200, 16'hFFFE, 16'h1234, 16'h0040, 16'h0080};
    localparam logic [7:0]  V_CNT  [NV] = '{8'd1, 8'd4, 8'd4, 8'd3, 8'd2, 8'd1};
    localparam logic [4:0]  V_WARN [NV] = '{5'd0, 5'd1, 5'd0, 5'd2, 5'd23, 5'd31};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic [7:0]  fetch_count = '0;
    logic [4:0]  warn_units = '0;
    logic busy, bus_req_n, as_n, uds_n, lds_n, rw, ad_oe, word_valid;
    logic [15:0] ad_out, ad_in, word_data, lat;
    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_f(input logic [15:0] x);
        return {x[7:0], x[15:8]} ^ 16'h3C5A;
    endfunction

    // Memory model: latch the address while it is driven, return data under strobe
    always_ff @(posedge clk) if (ad_oe) lat <= ad_out;
    assign ad_in = !uds_n ? mem_f(lat) : 16'h0000;

    dispbus_master dut (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_count(fetch_count), .warn_units(warn_units), .busy(busy),
        .bus_req_n(bus_req_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n), .rw(rw),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .word_data(word_data),
        .word_valid(word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_fetch(input logic [15:0] a, input logic [7:0] n, input logic [4:0] w, input bit poke);
        int eff;
        int k;
        logic [15:0] ea;
        eff = (w > 5'd23) ? 23 * 6 : int'(w) * 6;
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a; fetch_count = n; warn_units = w;
        @(negedge clk);
        fetch_req = 1'b0;
        chk(bus_req_n == 1'b0, "R3 br low after accept", 32'(bus_req_n), 0);
        chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
        k = 0;
        while (!ad_oe && k < 1000) begin
            @(negedge clk);
            k++;
            if (!ad_oe) chk(bus_req_n == 1'b0 && as_n == 1'b1, "R3 held in warning", 32'(bus_req_n), 0);
        end
        chk(k == eff, (w > 5'd23) ? "R10 clamped gap" : "R3 warning gap", 32'(k), 32'(eff));
        for (int i = 0; i < int'(n); i++) begin
            ea = a + 16'(i);
            chk(ad_oe && ad_out == ea && as_n && uds_n && lds_n, "R7 ADDR phase address", 32'(ad_out), 32'(ea));
            chk(rw == 1'b1, "R5 rw read", 32'(rw), 1);
            @(negedge clk);
            chk(!ad_oe && !as_n && !uds_n && !lds_n, "R4 STRB phase", {29'd0, ad_oe, as_n, uds_n}, 0);
            if (poke && i == 0) begin
                fetch_req = 1'b1; fetch_addr = 16'h7777; fetch_count = 8'd9;
            end
            @(negedge clk);
            fetch_req = 1'b0;
            chk(!ad_oe && !as_n && !uds_n && !lds_n, "R4 SAMP phase", {29'd0, ad_oe, as_n, uds_n}, 0);
            @(negedge clk);
            chk(word_valid && word_data == mem_f(ea), "R6 captured word", 32'(word_data), 32'(mem_f(ea)));
        end
        chk(!ad_oe && uds_n && lds_n && as_n && !bus_req_n, "R8 DRAIN cycle", {28'd0, ad_oe, uds_n, as_n, bus_req_n}, 32'h6);
        @(negedge clk);
        chk(bus_req_n && !busy && !word_valid, "R8 bus released", {30'd0, bus_req_n, busy}, 32'h2);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(bus_req_n && !busy && !ad_oe, "R2 stays idle after run", 32'(bus_req_n), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_req_n && as_n && uds_n && lds_n && !ad_oe && !word_valid && !busy,
            "R1 reset state", {25'd0, bus_req_n, as_n, uds_n, lds_n, ad_oe, word_valid, busy}, 32'h78);
        chk(rw == 1'b1, "R5 rw in reset", 32'(rw), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_req_n && !busy, "R1 idle after reset", 32'(bus_req_n), 1);

        for (int v = 0; v < NV; v++) run_fetch(V_ADDR[v], V_CNT[v], V_WARN[v], 1'b0);

        // R2: zero count ignored
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = 16'h0AAA; fetch_count = 8'd0; warn_units = 5'd0;
        @(negedge clk);
        fetch_req = 1'b0;
        for (int j = 0; j < 3; j++) begin
            chk(bus_req_n && !busy && !ad_oe, "R2 zero count ignored", 32'(busy), 0);
            @(negedge clk);
        end

        // R2: request during a run ignored
        run_fetch(16'h0500, 8'd2, 5'd1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule